// File: doc/BRIEF.md
# Real-Time Clock Register Core

This block keeps a calendar (seconds, minutes, hours, day of week, day of month, month, two-digit year) together with an alarm time and four control/status bytes. Everything sits behind a byte-wide two-port interface. A write on the index port selects one of sixteen locations, and a read or write on the data port then reaches that location.

A divider counts `TICK_CYCLES` clock cycles per second. For the last `UIP_CYCLES` cycles of each second, an update-in-progress status bit is raised. When that window closes, the calendar advances by one second. It carries into minutes, hours, days, months and years, in either binary or BCD and in either 24-hour or 12-hour format. The data format and the hour format are runtime mode bits, and the stored values are never converted when a mode changes.

On each advance the new time is compared against the alarm. Update-ended, alarm and periodic flags are collected in a status byte, which is cleared by reading it. A summary request bit and the `irq` output go high while any flag and its enable are both set. A freeze bit in control byte B stops the calendar so that software can load a new time.

Top module: `rtc_regcore`

## Requirements
- R1: A bus write with `port_sel`=0 loads `wdata[3:0]` as the register index. A data-port access (`port_sel`=1) reaches that register. Index map: 0 sec, 1 alarm sec, 2 min, 3 alarm min, 4 hour, 5 alarm hour, 6 day of week, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 status C, 13 status D. Indices 14 and 15 read 0x00 and ignore writes.
- R2: After reset, time and alarm are 0, day of week, day of month and month are 1, control A reads 0x00, control B reads 0x02, status C reads 0x00, and `irq` is low.
- R3: In BCD mode (control B bit 2 = 0) with 24-hour format (B bit 1 = 1), each advance adds one second with decimal digit carry (0x09 becomes 0x10). Seconds and minutes wrap at 59, hours wrap at 23, day of week goes 7→1, month goes 12→1 and year goes 99→0.
- R4: In binary mode (B bit 2 = 1) the same carries apply to plain binary values (0x09 becomes 0x0A).
- R5: In 12-hour format (B bit 1 = 0) hours run 1–12, with bit 7 set for PM. 11 AM advances to 12 PM (0x92 in BCD), and 11 PM advances to 12 AM (0x12), which also advances the day.
- R6: Day of month rolls to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in other months. February ends at day 29 when the year is divisible by 4 and at day 28 otherwise.
- R7: Writing the format bits of control B leaves the stored time and alarm bytes unchanged.
- R8: While control B bit 7 (freeze) is set, the calendar does not advance and the update-in-progress bit stays low. Clearing the bit restarts the one-second divider from zero.
- R9: Control A bit 7 is a read-only update-in-progress flag. It is high for the last `UIP_CYCLES` cycles before each advance, and the time bytes do not change while it is high. Control A bits 6:0 are read/write.
- R10: On an advance, the alarm flag is set when the new seconds, minutes and hours each equal their alarm byte. An alarm byte of 0xC0–0xFF matches any value.
- R11: Status C has four flag bits. Bit 4 (update ended) is set on every advance, bit 5 is the alarm flag and bit 6 is the periodic flag. Bit 7 is high when any flag is set together with its enable in control B bits 4/5/6, and `irq` follows bit 7. Bits 3:0 read 0. Reading C returns the flags and then clears them. Writes to C are ignored.
- R12: Control A bits 3:0 = r, when nonzero, set the periodic flag once every 2^r clock cycles. r = 0 produces no periodic flag.
- R13: Status D reads 0x80 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; a data-port read of status C clears it |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selected register on the data port, index on the index port |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
The calendar is loaded under freeze with edge values and advanced by one second in each combination of BCD/binary and 24/12-hour format. The `0x09` second seeds separate decimal from binary carry. 23:59:59 seeds reach the day, month and year carries and separate 30-day, 31-day, leap and non-leap February endings. Two 12-hour seeds separate the 11→12 PM-marker flip from the 12→1 wrap. Alarm seeds with wildcard bytes, plus a following non-matching second, separate a true alarm from the plain update flag. The periodic flag is tried at a fast rate and at rate zero, which separates a working divider from a stuck one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_TOD = 10;
  localparam int unsigned RATE_W  = 4;
  localparam int unsigned PER_W   = (1 << RATE_W) - 1;
  localparam int unsigned NFLAG   = 3;

  localparam logic [3:0] IX_SEC   = 4'd0;
  localparam logic [3:0] IX_ASEC  = 4'd1;
  localparam logic [3:0] IX_MIN   = 4'd2;
  localparam logic [3:0] IX_AMIN  = 4'd3;
  localparam logic [3:0] IX_HOUR  = 4'd4;
  localparam logic [3:0] IX_AHOUR = 4'd5;
  localparam logic [3:0] IX_WDAY  = 4'd6;
  localparam logic [3:0] IX_MDAY  = 4'd7;
  localparam logic [3:0] IX_MON   = 4'd8;
  localparam logic [3:0] IX_YEAR  = 4'd9;
  localparam logic [3:0] IX_CTLA  = 4'd10;
  localparam logic [3:0] IX_CTLB  = 4'd11;
  localparam logic [3:0] IX_STAT  = 4'd12;
  localparam logic [3:0] IX_VALID = 4'd13;

  // control B bit positions
  localparam int unsigned B_FREEZE = 7;
  localparam int unsigned B_BIN    = 2;
  localparam int unsigned B_H24    = 1;
  localparam int unsigned B_EN_LO  = 4; // enables for update/alarm/periodic at 4..6

  localparam logic [7:0] CTLB_RST  = 8'h02;
  localparam logic [7:0] VALID_VAL = 8'h80;

  // stored byte -> binary value
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    logic [6:0] r;
    if (bin) r = v[6:0];
    else     r = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    return r;
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    logic [7:0] r;
    tens = b / 7'd10;
    ones = b - tens * 7'd10;
    if (bin) r = {1'b0, b};
    else     r = 8'(tens) * 8'd16 + 8'(ones);
    return r;
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    logic [6:0] r;
    case (mon)
      7'd2:                    r = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: r = 7'd30;
      default:                 r = 7'd31;
    endcase
    return r;
  endfunction

  function automatic logic alarm_eq(input logic [7:0] a, input logic [7:0] v);
    return (a[7:6] == 2'b11) || (a == v);
  endfunction
endpackage

// File: rtl/rtc_tick.sv
module rtc_tick
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 200,
  parameter int unsigned UIP_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [RATE_W-1:0] rate,
  output logic              uip,
  output logic              step,
  output logic              per_pulse
);
  localparam int unsigned CW        = $clog2(TICK_CYCLES);
  localparam logic [CW-1:0] LAST    = CW'(TICK_CYCLES - 1);
  localparam logic [CW-1:0] UIP_BEG = CW'(TICK_CYCLES - UIP_CYCLES);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [PER_W-1:0] pcnt_q, pcnt_d, per_mask;

  always_comb begin
    if (hold || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + CW'(1);
    pcnt_d   = pcnt_q + PER_W'(1);
    per_mask = ~({PER_W{1'b1}} << rate);
  end

  assign uip       = (cnt_q >= UIP_BEG);
  assign step      = !hold && (cnt_q == LAST);
  assign per_pulse = (rate != '0) && ((pcnt_q & per_mask) == per_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R8: a held freeze keeps the update window closed
  assert_no_uip_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> !uip);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_idx,
  input  logic [7:0]               wr_data,
  input  logic                     step,
  input  logic                     bin_mode,
  input  logic                     h24_mode,
  output logic [NUM_TOD-1:0][7:0]  tod,
  output logic                     alarm_hit
);
  logic [NUM_TOD-1:0][7:0] tod_q, tod_d, adv;
  logic       wr_hit, tod_en, c_min, c_hr, c_day, c_mon, c_yr, pm;
  logic [6:0] s, m, h, h12, wd, md, mo, yr, mlen;
  logic [6:0] ns, nm, nh, nwd, nmd, nmo, nyr, t12;
  logic [7:0] hv;

  always_comb begin
    s   = to_bin(tod_q[IX_SEC],  bin_mode);
    m   = to_bin(tod_q[IX_MIN],  bin_mode);
    wd  = to_bin(tod_q[IX_WDAY], bin_mode);
    md  = to_bin(tod_q[IX_MDAY], bin_mode);
    mo  = to_bin(tod_q[IX_MON],  bin_mode);
    yr  = to_bin(tod_q[IX_YEAR], bin_mode);
    h12 = to_bin({1'b0, tod_q[IX_HOUR][6:0]}, bin_mode);
    if (h24_mode) h = to_bin(tod_q[IX_HOUR], bin_mode);
    else          h = ((h12 == 7'd12) ? 7'd0 : h12) + (tod_q[IX_HOUR][7] ? 7'd12 : 7'd0);

    c_min = (s >= 7'd59);
    ns    = c_min ? 7'd0 : s + 7'd1;
    c_hr  = c_min && (m >= 7'd59);
    nm    = c_min ? ((m >= 7'd59) ? 7'd0 : m + 7'd1) : m;
    c_day = c_hr && (h >= 7'd23);
    nh    = c_hr ? ((h >= 7'd23) ? 7'd0 : h + 7'd1) : h;
    nwd   = c_day ? ((wd >= 7'd7) ? 7'd1 : wd + 7'd1) : wd;
    mlen  = month_len(mo, yr);
    c_mon = c_day && (md >= mlen);
    nmd   = c_day ? ((md >= mlen) ? 7'd1 : md + 7'd1) : md;
    c_yr  = c_mon && (mo >= 7'd12);
    nmo   = c_mon ? ((mo >= 7'd12) ? 7'd1 : mo + 7'd1) : mo;
    nyr   = c_yr ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;

    pm  = (nh >= 7'd12);
    t12 = pm ? nh - 7'd12 : nh;
    if (t12 == 7'd0) t12 = 7'd12;
    hv  = from_bin(t12, bin_mode);

    adv           = tod_q;
    adv[IX_SEC]   = from_bin(ns, bin_mode);
    adv[IX_MIN]   = from_bin(nm, bin_mode);
    adv[IX_HOUR]  = h24_mode ? from_bin(nh, bin_mode) : {pm, hv[6:0]};
    adv[IX_WDAY]  = from_bin(nwd, bin_mode);
    adv[IX_MDAY]  = from_bin(nmd, bin_mode);
    adv[IX_MON]   = from_bin(nmo, bin_mode);
    adv[IX_YEAR]  = from_bin(nyr, bin_mode);

    wr_hit = wr_en && (wr_idx < 4'(NUM_TOD));
    tod_d  = tod_q;
    if (wr_hit) begin
      for (int i = 0; i < NUM_TOD; i++)
        if (wr_idx == 4'(i)) tod_d[i] = wr_data;
    end else if (step) begin
      tod_d = adv;
    end
    tod_en = wr_hit || step;

    alarm_hit = step && !wr_hit
             && alarm_eq(tod_q[IX_ASEC],  adv[IX_SEC])
             && alarm_eq(tod_q[IX_AMIN],  adv[IX_MIN])
             && alarm_eq(tod_q[IX_AHOUR], adv[IX_HOUR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q          <= '0;
      tod_q[IX_WDAY] <= 8'h01;
      tod_q[IX_MDAY] <= 8'h01;
      tod_q[IX_MON]  <= 8'h01;
    end else if (tod_en) begin
      tod_q <= tod_d;
    end
  end

  assign tod = tod_q;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,  // [0] update, [1] alarm, [2] periodic
  input  logic [NFLAG-1:0] en_vec,
  input  logic             clr,
  output logic [NFLAG-1:0] flags,
  output logic             irqf
);
  logic [NFLAG-1:0] flag_q, flag_d, flag_en;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_comb begin
      flag_d[g]  = set_vec[g];
      flag_en[g] = set_vec[g] || clr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (flag_en[g]) flag_q[g] <= flag_d[g];
    end
  end

  assign flags = flag_q;
  assign irqf  = |(flag_q & en_vec);

  // R11: a status read with no new event drops the request
  assert_irq_drop_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set_vec == '0)) |=> !irqf);
  // R11: every advance leaves the update flag set
  assert_update_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> flag_q[0]);
endmodule

// File: rtl/rtc_regcore.sv
module rtc_regcore
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 200,
  parameter int unsigned UIP_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       port_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [3:0] idx_q, idx_d;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic idx_we, data_we, ctla_en, ctlb_en, stat_rd;
  logic uip, step, per_pulse, alarm_hit, irqf;
  logic [NUM_TOD-1:0][7:0] tod;
  logic [NFLAG-1:0] flags;

  always_comb begin
    idx_we  = bus_wr && !port_sel;
    data_we = bus_wr && port_sel;
    idx_d   = wdata[3:0];
    ctla_en = data_we && (idx_q == IX_CTLA);
    ctlb_en = data_we && (idx_q == IX_CTLB);
    ctla_d  = wdata[6:0];
    ctlb_d  = wdata;
    stat_rd = bus_rd && port_sel && (idx_q == IX_STAT);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      idx_q  <= '0;
      ctla_q <= '0;
      ctlb_q <= CTLB_RST;
    end else begin
      if (idx_we)  idx_q  <= idx_d;
      if (ctla_en) ctla_q <= ctla_d;
      if (ctlb_en) ctlb_q <= ctlb_d;
    end
  end

  rtc_tick #(.TICK_CYCLES(TICK_CYCLES), .UIP_CYCLES(UIP_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_sync_q), .hold(ctlb_q[B_FREEZE]),
    .rate(ctla_q[RATE_W-1:0]), .uip(uip), .step(step), .per_pulse(per_pulse));

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(data_we), .wr_idx(idx_q), .wr_data(wdata),
    .step(step), .bin_mode(ctlb_q[B_BIN]), .h24_mode(ctlb_q[B_H24]),
    .tod(tod), .alarm_hit(alarm_hit));

  rtc_flags u_flags (
    .clk(clk), .rst_n(rst_sync_q), .set_vec({per_pulse, alarm_hit, step}),
    .en_vec(ctlb_q[B_EN_LO +: NFLAG]), .clr(stat_rd), .flags(flags), .irqf(irqf));

  always_comb begin
    rdata = 8'h00;
    if (!port_sel) begin
      rdata = {4'h0, idx_q};
    end else begin
      for (int i = 0; i < NUM_TOD; i++)
        if (idx_q == 4'(i)) rdata = tod[i];
      case (idx_q)
        IX_CTLA:  rdata = {uip, ctla_q};
        IX_CTLB:  rdata = ctlb_q;
        IX_STAT:  rdata = {irqf, flags, 4'h0};
        IX_VALID: rdata = VALID_VAL;
        default:  ;
      endcase
    end
  end

  assign irq = irqf;

  // R9: no time byte moves inside the update window unless the bus wrote it
  assert_tod_stable_in_uip_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (uip && $past(uip) && !$past(data_we)) |-> $stable(tod));
  // R12: with rate zero the periodic flag never appears
  assert_no_pf_rate0_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((ctla_q[RATE_W-1:0] == '0) && !flags[2]) |=> !flags[2]);
endmodule

// File: tb/rtc_regcore_bench.sv
module rtc_regcore_bench;
  localparam int TICK = 200;
  localparam int UIPW = 16;
  localparam logic [3:0] A_SEC = 4'd0, A_ASEC = 4'd1, A_MIN = 4'd2, A_AMIN = 4'd3,
    A_HOUR = 4'd4, A_AHOUR = 4'd5, A_WDAY = 4'd6, A_MDAY = 4'd7, A_MON = 4'd8,
    A_YEAR = 4'd9, A_CA = 4'd10, A_CB = 4'd11, A_SC = 4'd12, A_SD = 4'd13;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;
  logic rd_chk = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rtc_regcore #(.TICK_CYCLES(TICK), .UIP_CYCLES(UIPW)) u_rtc_regcore (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .port_sel(port_sel),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  // monitor: pops the scoreboard on every checked data-port read
  always @(negedge clk) begin : mon
    logic [7:0] e, mk;
    string t;
    if (bus_rd && port_sel && rd_chk) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: got %02h expected an entry", rdata);
      end else begin
        e = exp_q.pop_front(); mk = msk_q.pop_front(); t = tag_q.pop_front();
        if ((rdata & mk) !== (e & mk)) begin
          n_fail++;
          $display("FAIL %s: got %02h expected %02h", t, rdata & mk, e & mk);
        end
      end
    end
  end

  task automatic wr_reg(input logic [3:0] ix, input logic [7:0] v);
    @(posedge clk); #1; bus_wr = 1'b1; port_sel = 1'b0; wdata = {4'h0, ix};
    @(posedge clk); #1; port_sel = 1'b1; wdata = v;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] ix, output logic [7:0] v);
    @(posedge clk); #1; bus_wr = 1'b1; port_sel = 1'b0; wdata = {4'h0, ix};
    @(posedge clk); #1; bus_wr = 1'b0; port_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk); v = rdata;
    @(posedge clk); #1; bus_rd = 1'b0; rd_chk = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] ix, input logic [7:0] e,
                            input logic [7:0] mk, input string tag);
    logic [7:0] v;
    exp_q.push_back(e); msk_q.push_back(mk); tag_q.push_back(tag);
    rd_chk = 1'b1;
    rd_reg(ix, v);
  endtask

  task automatic check_irq(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
    end
  endtask

  task automatic wait_update();
    logic [7:0] v;
    v = 8'h00;
    for (int g = 0; g < 2000 && !v[7]; g++) rd_reg(A_CA, v);
    for (int g = 0; g < 2000 && v[7]; g++) rd_reg(A_CA, v);
  endtask

  task automatic clear_stat();
    logic [7:0] v;
    rd_reg(A_SC, v);
  endtask

  // load a full calendar under freeze, then release with the given mode byte
  task automatic load_time(input logic [7:0] mode, input logic [7:0] sec, input logic [7:0] mn,
                           input logic [7:0] hr, input logic [7:0] wd, input logic [7:0] md,
                           input logic [7:0] mo, input logic [7:0] yr);
    wr_reg(A_CB, mode | 8'h80);
    wr_reg(A_SEC, sec); wr_reg(A_MIN, mn); wr_reg(A_HOUR, hr);
    wr_reg(A_WDAY, wd); wr_reg(A_MDAY, md); wr_reg(A_MON, mo); wr_reg(A_YEAR, yr);
    wr_reg(A_CB, mode);
  endtask

  bit done = 1'b0;
  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : driver
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 reset state
    check_irq(1'b0, "R2 irq after reset");
    expect_reg(A_CB, 8'h02, 8'hFF, "R2 control B reset");
    expect_reg(A_CA, 8'h00, 8'hFF, "R2 control A reset");
    expect_reg(A_SC, 8'h00, 8'hFF, "R2 status reset");
    expect_reg(A_SEC, 8'h00, 8'hFF, "R2 seconds reset");
    expect_reg(A_WDAY, 8'h01, 8'hFF, "R2 weekday reset");
    expect_reg(A_MON, 8'h01, 8'hFF, "R2 month reset");

    // R1 addressing, R13 valid byte
    wr_reg(A_CB, 8'h82);
    wr_reg(A_ASEC, 8'h33);
    expect_reg(A_ASEC, 8'h33, 8'hFF, "R1 alarm seconds readback");
    wr_reg(4'd15, 8'h55);
    expect_reg(4'd15, 8'h00, 8'hFF, "R1 index 15 reads zero");
    expect_reg(4'd14, 8'h00, 8'hFF, "R1 index 14 reads zero");
    wr_reg(A_SD, 8'h00);
    expect_reg(A_SD, 8'h80, 8'hFF, "R13 valid byte");
    // R9 bit 7 of A is read-only
    wr_reg(A_CA, 8'h80);
    expect_reg(A_CA, 8'h00, 8'hFF, "R9 A bit7 read-only");

    // R8 freeze holds the calendar
    wr_reg(A_SEC, 8'h10);
    repeat (3 * TICK) @(posedge clk);
    expect_reg(A_SEC, 8'h10, 8'hFF, "R8 seconds frozen");
    expect_reg(A_CA, 8'h00, 8'h80, "R8 no UIP while frozen");

    // R3 BCD decimal carry, then full carry chain
    load_time(8'h02, 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wait_update();
    expect_reg(A_SEC, 8'h10, 8'hFF, "R3 BCD 09->10");
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    wait_update();
    expect_reg(A_SEC, 8'h00, 8'hFF, "R3 sec wrap");
    expect_reg(A_MIN, 8'h00, 8'hFF, "R3 min wrap");
    expect_reg(A_HOUR, 8'h00, 8'hFF, "R3 hour wrap");
    expect_reg(A_WDAY, 8'h01, 8'hFF, "R3 weekday wrap");
    expect_reg(A_MDAY, 8'h01, 8'hFF, "R3 mday wrap");
    expect_reg(A_MON, 8'h01, 8'hFF, "R3 month wrap");
    expect_reg(A_YEAR, 8'h00, 8'hFF, "R3 year wrap");

    // R9 time stable inside the update window
    load_time(8'h02, 8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    v = 8'h00;
    for (int g = 0; g < 2000 && !v[7]; g++) rd_reg(A_CA, v);
    expect_reg(A_SEC, 8'h20, 8'hFF, "R9 seconds held during UIP");
    for (int g = 0; g < 2000 && v[7]; g++) rd_reg(A_CA, v);
    expect_reg(A_SEC, 8'h21, 8'hFF, "R9 seconds after UIP");

    // R4 binary carry
    load_time(8'h06, 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wait_update();
    expect_reg(A_SEC, 8'h0A, 8'hFF, "R4 binary 09->0A");

    // R6 month lengths
    load_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h01, 8'h1C, 8'h02, 8'h18);
    wait_update();
    expect_reg(A_MDAY, 8'h1D, 8'hFF, "R6 leap Feb 28->29 (R4 binary)");
    expect_reg(A_MON, 8'h02, 8'hFF, "R6 leap month kept");
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    wait_update();
    expect_reg(A_MDAY, 8'h01, 8'hFF, "R6 non-leap Feb end");
    expect_reg(A_MON, 8'h03, 8'hFF, "R6 non-leap to March");
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    wait_update();
    expect_reg(A_MON, 8'h05, 8'hFF, "R6 April 30 ends month");
    load_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h23);
    wait_update();
    expect_reg(A_MDAY, 8'h31, 8'hFF, "R6 May 30->31");

    // R5 12-hour format
    load_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h03, 8'h01, 8'h01, 8'h00);
    wait_update();
    expect_reg(A_HOUR, 8'h92, 8'hFF, "R5 11AM->12PM");
    expect_reg(A_WDAY, 8'h03, 8'hFF, "R5 no day change at noon");
    load_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h03, 8'h01, 8'h01, 8'h00);
    wait_update();
    expect_reg(A_HOUR, 8'h81, 8'hFF, "R5 12PM->1PM");
    load_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h03, 8'h01, 8'h01, 8'h00);
    wait_update();
    expect_reg(A_HOUR, 8'h12, 8'hFF, "R5 11PM->12AM");
    expect_reg(A_WDAY, 8'h04, 8'hFF, "R5 day advance at midnight");

    // R7 format change keeps stored bytes
    wr_reg(A_CB, 8'h82);
    wr_reg(A_SEC, 8'h45); wr_reg(A_HOUR, 8'h15);
    wr_reg(A_CB, 8'h86);
    expect_reg(A_SEC, 8'h45, 8'hFF, "R7 seconds kept after binary switch");
    wr_reg(A_CB, 8'h84);
    expect_reg(A_HOUR, 8'h15, 8'hFF, "R7 hour kept after 12h switch");

    // R10 alarm with wildcards, R11 flags and clear-on-read
    wr_reg(A_CB, 8'hA2);
    wr_reg(A_SEC, 8'h59); wr_reg(A_MIN, 8'h20); wr_reg(A_HOUR, 8'h10);
    wr_reg(A_ASEC, 8'h00); wr_reg(A_AMIN, 8'hC0); wr_reg(A_AHOUR, 8'hFF);
    wr_reg(A_CB, 8'h22);
    clear_stat();
    wait_update();
    check_irq(1'b1, "R11 irq on enabled alarm");
    expect_reg(A_SC, 8'hB0, 8'hFF, "R10 alarm match flags");
    check_irq(1'b0, "R11 irq dropped after read");
    expect_reg(A_SC, 8'h00, 8'hFF, "R11 flags cleared by read");
    wait_update();
    expect_reg(A_SC, 8'h10, 8'hFF, "R10 no match at second 01");
    wr_reg(A_CB, 8'h12);
    wait_update();
    expect_reg(A_SC, 8'h90, 8'hFF, "R11 update flag with enable");

    // R12 periodic flag, R11 write to status ignored
    wr_reg(A_CB, 8'h82);
    wr_reg(A_CA, 8'h03);
    expect_reg(A_CA, 8'h03, 8'h7F, "R9 A low bits read/write");
    clear_stat();
    repeat (20) @(posedge clk);
    expect_reg(A_SC, 8'h40, 8'hFF, "R12 periodic flag at rate 3");
    wr_reg(A_CB, 8'hC2);
    repeat (20) @(posedge clk);
    expect_reg(A_SC, 8'hC0, 8'hFF, "R12 periodic with enable");
    wr_reg(A_CA, 8'h00);
    clear_stat();
    repeat (60) @(posedge clk);
    expect_reg(A_SC, 8'h00, 8'hFF, "R12 no periodic at rate 0");
    wr_reg(A_SC, 8'hF0);
    expect_reg(A_SC, 8'h00, 8'hFF, "R11 status write ignored");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule